// File: doc/BRIEF.md
# Millisecond and Seconds Real-Time Clock with Bus Register Port

This block keeps wall-clock time as a seconds count and a millisecond count, both advanced by a slow tick input of about 32 kHz. A prescaler turns the tick into milliseconds. The millisecond count wraps into the seconds count.

Software sees the time through a small read/write register port. The live counts are copied to the register side once every eight ticks. A busy flag is raised for a few clock cycles after each copy, and writes that arrive during that window are discarded. Reading the millisecond register also captures the posted seconds value into a shadow register, so a millisecond read followed by a shadow read always returns a matching pair.

Two seconds-compare alarms raise bits in a write-one-to-clear status register. A mask register decides which status bits drive the single active-high level interrupt.

Top module: `sec_rtc`

## Requirements
- R1: After reset every register reads 0, including the busy flag, and `irq` is low.
- R2: The millisecond count advances once every TICKS_PER_MS ticks. On the step from MS_WRAP-1 it returns to 0 and the seconds count advances by one. The seconds count wraps from all ones to 0.
- R3: On every PUBLISH_TICKS-th tick since reset, the live counts are copied to the posted values. Offset 0x008 reads the posted seconds and offset 0x010 reads the posted milliseconds. Between copies the posted values do not change.
- R4: Bit 0 of offset 0x004 reads 1 for exactly BUSY_CYCLES clock cycles, starting on the cycle after the tick that caused a copy. At all other times it reads 0.
- R5: A write issued while busy is 1 is dropped and changes no register.
- R6: A write to offset 0x008 loads the seconds count and clears the milliseconds and the prescaler. The written value is readable at once.
- R7: A read of offset 0x010 copies the posted seconds into the shadow register at offset 0x00C. The shadow register changes at no other time.
- R8: Status bit 0 (alarm register at 0x014) or status bit 1 (alarm register at 0x018) sets when the seconds count steps to a value equal to that nonzero alarm register. This happens whatever the mask holds.
- R9: An alarm register holding 0 never sets its status bit, including when the seconds count wraps to 0.
- R10: Writing a 1 to a bit of the status register at 0x02C clears that bit. Writing a 0 leaves it unchanged.
- R11: `irq` is high, one cycle after the condition, exactly when some status bit and the matching bit of the mask register at 0x028 are both set.
- R12: Status and mask bits 2 to 4, and the millisecond alarm register at 0x01C, always read 0 whatever is written to them.
- R13: Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per 32 kHz period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, active high |

## Verification
The hardest case to reach from the ports is a write that lands inside the short busy window right after a copy. The bench keeps its own count of ticks since reset, so it knows which tick causes a copy and can issue the write on the very next cycle. It then reads the targeted registers back to confirm the write was dropped.

The second hard case is a seconds count wrapping to zero while an alarm register holds zero. The bench reaches it by loading an all-ones seconds value and ticking through one second.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int ADDR_W  = 8;
  localparam int NUM_ALM = 2;   // seconds-compare alarms; status bits 0 and 1
  localparam logic [ADDR_W-1:0] OFF_BUSY   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_SEC    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SHADOW = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MS     = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_ALM0   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_ALM1   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_MSALM  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h2C;
endpackage

// File: rtl/sec_rtc_timebase.sv
module sec_rtc_timebase #(
  parameter int TICKS_PER_MS  = 32,
  parameter int MS_WRAP       = 1000,
  parameter int PUBLISH_TICKS = 8,
  parameter int BUSY_CYCLES   = 4,
  parameter int SEC_W         = 32,
  localparam int MS_W  = $clog2(MS_WRAP),
  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1,
  localparam int PUB_W = (PUBLISH_TICKS > 1) ? $clog2(PUBLISH_TICKS) : 1,
  localparam int BSY_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_en,
  input  logic [SEC_W-1:0] load_sec,
  output logic             step_o,
  output logic [SEC_W-1:0] step_val_o,
  output logic [SEC_W-1:0] pub_sec_o,
  output logic [MS_W-1:0]  pub_ms_o,
  output logic             busy_o
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic [PUB_W-1:0] pub_q;
  logic [BSY_W-1:0] bsy_q;
  logic pre_last, ms_last, pub_last, ms_adv, sec_adv;

  always_comb begin
    pre_last = (pre_q == PRE_W'(TICKS_PER_MS - 1));
    ms_last  = (ms_q == MS_W'(MS_WRAP - 1));
    pub_last = (pub_q == PUB_W'(PUBLISH_TICKS - 1));
    ms_adv   = tick && pre_last;
    sec_adv  = ms_adv && ms_last;
    pre_d    = pre_last ? '0 : pre_q + 1'b1;
    ms_d     = ms_adv ? (ms_last ? '0 : ms_q + 1'b1) : ms_q;
    sec_d    = sec_adv ? sec_q + 1'b1 : sec_q;
  end

  assign step_o     = sec_adv && !load_en;
  assign step_val_o = sec_q + 1'b1;
  assign busy_o     = (bsy_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0; ms_q <= '0; sec_q <= '0; pub_q <= '0;
      pub_sec_o <= '0; pub_ms_o <= '0;
    end else if (load_en) begin
      pre_q <= '0; ms_q <= '0; sec_q <= load_sec;
      pub_sec_o <= load_sec; pub_ms_o <= '0;
    end else if (tick) begin
      pre_q <= pre_d; ms_q <= ms_d; sec_q <= sec_d;
      pub_q <= pub_last ? '0 : pub_q + 1'b1;
      if (pub_last) begin
        pub_sec_o <= sec_d;
        pub_ms_o  <= ms_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                bsy_q <= '0;
    else if (tick && pub_last && !load_en)  bsy_q <= BSY_W'(BUSY_CYCLES);
    else if (bsy_q != '0)                   bsy_q <= bsy_q - 1'b1;
  end
endmodule

// File: rtl/sec_rtc_alarm_cmp.sv
module sec_rtc_alarm_cmp #(
  parameter int NUM   = 2,
  parameter int SEC_W = 32
) (
  input  logic             step,
  input  logic [SEC_W-1:0] step_val,
  input  logic [SEC_W-1:0] alarm [NUM],
  output logic [NUM-1:0]   hit
);
  for (genvar i = 0; i < NUM; i++) begin : g_cmp
    assign hit[i] = step && (alarm[i] != '0) && (alarm[i] == step_val);
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int TICKS_PER_MS  = 32,
  parameter int MS_WRAP       = 1000,
  parameter int PUBLISH_TICKS = 8,
  parameter int BUSY_CYCLES   = 4,
  parameter int SEC_W         = 32,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int MS_W = $clog2(MS_WRAP);
  localparam logic [ADDR_W-1:0] ALM_OFF [NUM_ALM] = '{OFF_ALM0, OFF_ALM1};

  logic             busy, wr_ok, load_en, step;
  logic [SEC_W-1:0] step_val, pub_sec, shadow_q;
  logic [MS_W-1:0]  pub_ms;
  logic [SEC_W-1:0] alarm_q [NUM_ALM];
  logic [NUM_ALM-1:0] hit, mask_q, stat_q, clr;
  logic [DATA_W-1:0]  rd_val;

  assign wr_ok   = bus_wr && !busy;
  assign load_en = wr_ok && (bus_addr == OFF_SEC);

  sec_rtc_timebase #(
    .TICKS_PER_MS(TICKS_PER_MS), .MS_WRAP(MS_WRAP),
    .PUBLISH_TICKS(PUBLISH_TICKS), .BUSY_CYCLES(BUSY_CYCLES), .SEC_W(SEC_W)
  ) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .load_en(load_en),
    .load_sec(bus_wdata[SEC_W-1:0]), .step_o(step), .step_val_o(step_val),
    .pub_sec_o(pub_sec), .pub_ms_o(pub_ms), .busy_o(busy)
  );

  sec_rtc_alarm_cmp #(.NUM(NUM_ALM), .SEC_W(SEC_W)) u_cmp (
    .step(step), .step_val(step_val), .alarm(alarm_q), .hit(hit)
  );

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_alm
    always_ff @(posedge clk) begin
      if (rst) alarm_q[i] <= '0;
      else if (wr_ok && bus_addr == ALM_OFF[i]) alarm_q[i] <= bus_wdata[SEC_W-1:0];
    end
  end

  assign clr = (wr_ok && bus_addr == OFF_STAT) ? bus_wdata[NUM_ALM-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0; stat_q <= '0; irq <= 1'b0; shadow_q <= '0;
    end else begin
      if (wr_ok && bus_addr == OFF_MASK) mask_q <= bus_wdata[NUM_ALM-1:0];
      stat_q <= (stat_q & ~clr) | hit;
      irq    <= |(stat_q & mask_q);
      if (bus_rd && bus_addr == OFF_MS) shadow_q <= pub_sec;
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      OFF_BUSY:    rd_val[0] = busy;
      OFF_SEC:     rd_val[SEC_W-1:0] = pub_sec;
      OFF_SHADOW:  rd_val[SEC_W-1:0] = shadow_q;
      OFF_MS:      rd_val[MS_W-1:0] = pub_ms;
      OFF_ALM0:    rd_val[SEC_W-1:0] = alarm_q[0];
      OFF_ALM1:    rd_val[SEC_W-1:0] = alarm_q[1];
      OFF_MASK:    rd_val[NUM_ALM-1:0] = mask_q;
      OFF_STAT:    rd_val[NUM_ALM-1:0] = stat_q;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
  import sec_rtc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int MS_W  = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic              busy,
  input logic              load_en,
  input logic [NUM_ALM-1:0] hit,
  input logic [NUM_ALM-1:0] stat,
  input logic [NUM_ALM-1:0] mask,
  input logic [SEC_W-1:0]  alarm0,
  input logic [MS_W-1:0]   pub_ms
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !irq && stat == '0));

  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == OFF_ALM0) |=> $stable(alarm0));

  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && bus_wr && bus_addr == OFF_STAT && bus_wdata[0] && !hit[0]) |=> !stat[0]);

  // R8
  alarm_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit[0] |=> stat[0]);

  // R11
  irq_high_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat & mask)) |=> irq);

  // R11
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & mask)) |=> !irq);

  // R3
  pub_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_en) |=> $stable(pub_ms));
endmodule

bind sec_rtc sec_rtc_chk #(.SEC_W(SEC_W), .MS_W(MS_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .busy(busy), .load_en(load_en),
  .hit(hit), .stat(stat_q), .mask(mask_q), .alarm0(alarm_q[0]), .pub_ms(pub_ms)
);

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;
  localparam int TPM = 2;
  localparam int MSW = 10;
  localparam int PUB = 8;
  localparam int BSY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;

  int n_chk = 0, n_err = 0;
  int gticks = 0, lticks = 0;
  logic [31:0] base = 0, p_sec = 0, p_ms = 0, rd;

  always #10 clk = ~clk;

  sec_rtc #(.TICKS_PER_MS(TPM), .MS_WRAP(MSW), .PUBLISH_TICKS(PUB),
            .BUSY_CYCLES(BSY), .SEC_W(32), .DATA_W(32)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [31:0] m_sec(int l);
    return base + 32'((l / TPM) / MSW);
  endfunction
  function automatic logic [31:0] m_ms(int l);
    return 32'((l / TPM) % MSW);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    gticks++; lticks++;
    if (gticks % PUB == 0) begin
      p_sec = m_sec(lticks);
      p_ms  = m_ms(lticks);
    end
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic raw_wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    for (int i = 0; i < BSY + 1; i++) @(negedge clk);
    raw_wr(a, d);
    if (a == 8'h08) begin
      base = d; lticks = 0; p_sec = d; p_ms = 0;
    end
  endtask

  task automatic tick_to_pub();
    do_tick();
    while (gticks % PUB != 0) do_tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] old_sh, tgt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", {31'd0, irq}, 0);
    foreach (u_dut.ALM_OFF[i]) begin end
    for (int a = 4; a <= 8'h2C; a += 4) begin
      rd_reg(8'(a), rd);
      chk("R1 reg", rd, 0);
    end

    // R4: busy window after a copy, none after an ordinary tick
    for (int k = 0; k < PUB - 1; k++) begin
      do_tick();
      rd_reg(8'h04, rd);
      chk("R4 busy idle", rd, 0);
    end
    do_tick();
    for (int c = 0; c < BSY; c++) begin
      rd_reg(8'h04, rd);
      chk("R4 busy high", rd, 1);
    end
    rd_reg(8'h04, rd);
    chk("R4 busy end", rd, 0);

    // R2 R3 R7: sweep across several second boundaries
    for (int k = 0; k < 30; k++) begin
      tick_to_pub();
      rd_reg(8'h10, rd);  chk("R2 ms", rd, p_ms);
      rd_reg(8'h0C, rd);  chk("R7 shadow", rd, p_sec);
      rd_reg(8'h08, rd);  chk("R3 sec", rd, p_sec);
    end

    // R3: posted values hold between copies
    repeat (4) do_tick();
    rd_reg(8'h10, rd); chk("R3 hold ms", rd, p_ms);

    // R7: shadow keeps its value without a new ms read
    tick_to_pub();
    rd_reg(8'h10, rd);
    old_sh = p_sec;
    repeat (5) tick_to_pub();
    rd_reg(8'h0C, rd); chk("R7 shadow hold", rd, old_sh);
    rd_reg(8'h08, rd); chk("R7 sec moved", rd, p_sec);

    // R6: load seconds, ms cleared
    wr_reg(8'h08, 32'd100);
    rd_reg(8'h08, rd); chk("R6 load sec", rd, 100);
    rd_reg(8'h10, rd); chk("R6 load ms", rd, 0);
    for (int k = 0; k < 6; k++) begin
      tick_to_pub();
      rd_reg(8'h08, rd); chk("R6 count sec", rd, p_sec);
      rd_reg(8'h10, rd); chk("R6 count ms", rd, p_ms);
    end

    // R5: writes inside the busy window are dropped
    wr_reg(8'h14, 32'd7);
    tick_to_pub();
    raw_wr(8'h08, 32'd555);
    raw_wr(8'h14, 32'd9);
    rd_reg(8'h08, rd); chk("R5 sec kept", rd, p_sec);
    rd_reg(8'h14, rd); chk("R5 alarm kept", rd, 7);

    // R12: reserved fields
    wr_reg(8'h28, 32'h1F);
    rd_reg(8'h28, rd); chk("R12 mask", rd, 32'h3);
    wr_reg(8'h1C, 32'hFFFF);
    rd_reg(8'h1C, rd); chk("R12 ms alarm", rd, 0);
    wr_reg(8'h28, 32'h0);
    // R13: unmapped
    rd_reg(8'h40, rd); chk("R13 unmapped", rd, 0);

    // R8: alarm0 fires without mask, irq stays low
    tgt = m_sec(lticks) + 2;
    wr_reg(8'h14, tgt);
    while (m_sec(lticks + 1) < tgt) do_tick();
    rd_reg(8'h2C, rd); chk("R8 before", rd, 0);
    do_tick();
    rd_reg(8'h2C, rd); chk("R8 alarm0 set", rd, 32'h1);
    chk("R11 masked", {31'd0, irq}, 0);

    // R11: unmask
    wr_reg(8'h28, 32'h1);
    @(negedge clk);
    chk("R11 irq high", {31'd0, irq}, 1);

    // R10: write-one-to-clear
    wr_reg(8'h2C, 32'h0);
    rd_reg(8'h2C, rd); chk("R10 zero keeps", rd, 32'h1);
    wr_reg(8'h2C, 32'h1);
    rd_reg(8'h2C, rd); chk("R10 cleared", rd, 0);
    @(negedge clk);
    chk("R11 irq low", {31'd0, irq}, 0);

    // R9: wrap to zero with alarm1 zero, alarm0 nonzero elsewhere
    wr_reg(8'h14, 32'd50);
    wr_reg(8'h28, 32'h3);
    wr_reg(8'h08, 32'hFFFF_FFFF);
    repeat (TPM * MSW + 2) do_tick();
    rd_reg(8'h10, rd);
    rd_reg(8'h0C, rd);
    rd_reg(8'h2C, rd); chk("R9 zero alarm", rd, 0);
    chk("R9 irq", {31'd0, irq}, 0);
    chk("R2 wrap", m_sec(lticks), 0);
    tick_to_pub();
    rd_reg(8'h08, rd); chk("R2 sec wrap", rd, p_sec);

    // R8: alarm1
    wr_reg(8'h18, 32'd2);
    while (m_sec(lticks) < 2) do_tick();
    rd_reg(8'h2C, rd); chk("R8 alarm1 set", rd, 32'h2);
    @(negedge clk);
    chk("R11 irq alarm1", {31'd0, irq}, 1);

    finish_run();
  end
endmodule